// File: doc/BRIEF.md
# MDIO Management Master with Host Register Bank

This block drives a Clause 22 management bus (MDC clock and bidirectional MDIO data) for a host that sees only three 16-bit registers. To write a PHY register, the host first puts the 16-bit value into the data register. It then writes a control word that holds the PHY address, the register number and an operation code. To read, only the control word is needed. A control write with a valid operation code launches a frame right away, and no separate go bit is needed.

While a frame runs, the idle flag in the control register reads as zero. When a read frame completes, the 16 bits taken from the PHY are copied into the receive register. They stay there until the next read frame completes. MDC comes from the system clock through a divider of `DIV_HALF` clocks per half period. The default of 40 gives 2.5 MHz from a 200 MHz clock, and a whole frame then lasts about 26 µs.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Host registers sit at byte offsets 0x0 (control/status), 0x2 (write data) and 0x4 (receive data), and other offsets read as zero. Reading 0x0 returns bits [11:0] of the last accepted control word, bit 12 set when idle, and bits [15:13] zero. After reset, offset 0x0 reads 0x1000 and the other two registers read 0.
- R2: In a control word, bits [4:0] are the register number, bits [9:5] the PHY address and bits [11:10] the operation. Operation 2 launches a read frame and operation 1 launches a write frame, both on the clock edge that takes the write.
- R3: A control write whose operation is 0 or 3 launches nothing, leaves the readback unchanged and produces no MDC edge.
- R4: A write frame sends, MSB first, 32 ones, start bits 01, operation bits 01, 5 address bits, 5 register bits, turnaround bits 10 and the 16 data bits. The output enable is high for all 64 bits.
- R5: A read frame sends the same header with operation bits 10. The output enable drops from the first turnaround bit onward. MDIO is sampled on the MDC rising edges of bit positions 48 to 63, and the result goes into offset 0x4, MSB first.
- R6: The receive register changes only when a read frame completes. Write frames and ignored writes leave it unchanged.
- R7: MDC is low when idle. While busy, MDC spends exactly `DIV_HALF` clocks low and then `DIV_HALF` clocks high, for 65 periods per frame.
- R8: MDIO changes only at MDC falling edges, so it is stable whenever MDC is high.
- R9: A control write that arrives while busy is ignored. The running frame and the control readback are unaffected.
- R10: A write frame uses the data-register value held at launch. A write to 0x2 during the frame updates the register but not the frame.
- R11: The idle flag sets exactly `130*DIV_HALF` clock edges after the launching edge, which is one MDC period after the last data bit. In idle the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host write strobe qualifier |
| we_i | input | 1 | Host write enable |
| addr_i | input | 3 | Host byte offset |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, combinational on addr_i |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest case to reach is a host access that lands in the middle of a running frame. This covers both a launch attempt that must be dropped and a data-register update that must not leak into the serial stream. The bench places both accesses at a fixed cycle inside the frame, within the same polling loop that times the frame. It then compares every captured MDIO bit and the final readbacks against values computed from the original request. The rest of the stimulus is a sweep over all 32 PHY addresses and all 32 register numbers, in both directions. Read data is generated arithmetically by a PHY model that drives MDIO after each MDC falling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int IDX_W     = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSV  = 2'd3
  } mdio_op_e;

  localparam logic [2:0] OFS_CTL = 3'h0;
  localparam logic [2:0] OFS_WD  = 3'h2;
  localparam logic [2:0] OFS_RD  = 3'h4;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == LAST);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdat_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rx_o
);
  localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic                 busy_q, rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] tx_q;
  logic [15:0]          sh_q, rx_q;
  logic                 oe;
  logic                 in_data;

  assign oe        = busy_q && (idx_q < (rd_q ? TA_IDX : END_IDX));
  assign in_data   = (idx_q >= DATA_IDX) && (idx_q < END_IDX);
  assign busy_o    = busy_q;
  assign mdio_oe_o = oe;
  assign mdio_o    = oe ? tx_q[FRAME_LEN-1] : 1'b1;
  assign rx_o      = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= is_rd_i;
      idx_q  <= '0;
      tx_q   <= {32'hFFFF_FFFF, 2'b01, (is_rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
                 (is_rd_i ? 2'b11 : 2'b10), (is_rd_i ? 16'hFFFF : wdat_i)};
    end else if (busy_q) begin
      if (rise_i && rd_q && in_data) sh_q <= {sh_q[14:0], mdio_i};
      if (fall_i) begin
        if (idx_q == END_IDX) begin
          busy_q <= 1'b0;
          if (rd_q) rx_q <= sh_q;
        end else begin
          idx_q <= idx_q + 1'b1;
          tx_q  <= {tx_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic        busy_i,
  input  logic [15:0] rx_i,
  output logic        start_o,
  output logic        is_rd_o,
  output logic [4:0]  phy_o,
  output logic [4:0]  reg_o,
  output logic [15:0] wdat_o,
  output logic [11:0] ctl_o,
  output logic [15:0] rdata_o
);
  logic [11:0] ctl_q;
  logic [15:0] wdat_q;
  logic        ctl_wr, op_ok;
  mdio_op_e    op;

  assign op      = mdio_op_e'(wdata_i[11:10]);
  assign ctl_wr  = req_i && we_i && (addr_i == OFS_CTL);
  assign op_ok   = (op == OP_RD) || (op == OP_WR);
  assign start_o = ctl_wr && op_ok && !busy_i;
  assign is_rd_o = (op == OP_RD);
  assign phy_o   = wdata_i[9:5];
  assign reg_o   = wdata_i[4:0];
  assign wdat_o  = wdat_q;
  assign ctl_o   = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      wdat_q <= '0;
    end else begin
      if (start_o) ctl_q <= wdata_i[11:0];
      if (req_i && we_i && (addr_i == OFS_WD)) wdat_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_CTL: rdata_o = {3'b000, ~busy_i, ctl_q};
      OFS_WD:  rdata_o = wdat_q;
      OFS_RD:  rdata_o = rx_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_HALF = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        busy, start, is_rd, rise, fall;
  logic [4:0]  phy, rg;
  logic [15:0] wdat, rx_word;
  logic [11:0] ctl_word;

  mdio_host_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .busy_i  (busy),
    .rx_i    (rx_word),
    .start_o (start),
    .is_rd_o (is_rd),
    .phy_o   (phy),
    .reg_o   (rg),
    .wdat_o  (wdat),
    .ctl_o   (ctl_word),
    .rdata_o
  );

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
    .clk_i, .rst_ni,
    .run_i  (busy),
    .mdc_o,
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shift (
    .clk_i, .rst_ni,
    .start_i (start),
    .is_rd_i (is_rd),
    .phy_i   (phy),
    .reg_i   (rg),
    .wdat_i  (wdat),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i,
    .busy_o  (busy),
    .mdio_o,
    .mdio_oe_o,
    .rx_o    (rx_word)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [2:0]  addr_i,
  input logic        mdc_i,
  input logic        mdio_i,
  input logic        oe_i,
  input logic        busy_i,
  input logic [11:0] ctl_i,
  input logic [15:0] rx_i
);
  a_r7_mdc_low_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);

  a_r11_released_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);

  a_r8_mdio_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_i) && $stable(oe_i)));

  a_r9_busy_ctl_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && req_i && we_i && addr_i == 3'h0) |=> $stable(ctl_i));

  a_r6_rx_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!busy_i || $stable(rx_i)));

  a_r6_rx_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(rx_i));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .mdc_i   (mdc_o),
  .mdio_i  (mdio_o),
  .oe_i    (mdio_oe_o),
  .busy_i  (busy),
  .ctl_i   (ctl_word),
  .rx_i    (rx_word)
);

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
module mdio_mgmt_master_test;
  localparam int H = 2;
  localparam int WD_LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = 3'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0, cycles = 0;

  // PHY model state
  logic        phy_rd = 1'b0;
  logic [15:0] phy_val = 16'h0;
  int          rise_cnt = 0, fall_cnt = 0;
  logic [63:0] cap_bits, cap_oe;
  logic        oe_tail;

  mdio_mgmt_master #(.DIV_HALF(H)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp<%0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_bits[63-rise_cnt] = mdio_o;
      cap_oe[63-rise_cnt]   = mdio_oe;
    end else begin
      oe_tail = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    fall_cnt = fall_cnt + 1;
    if (phy_rd && fall_cnt >= 48 && fall_cnt <= 63) mdio_i = phy_val[63-fall_cnt];
    else mdio_i = 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; addr = 3'h0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata; addr = 3'h0;
  endtask

  // run one frame; inj: issue a busy control write and a data write mid-frame
  task automatic frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wv, input logic [15:0] rv, input logic inj);
    logic [63:0] exp_bits, exp_oe;
    logic [15:0] v, ctl_exp;
    int n, hi;
    logic idle;
    reg_wr(3'h2, rd ? ~rv : wv);
    phy_rd = rd; phy_val = rv; rise_cnt = 0; fall_cnt = 0;
    oe_tail = 1'b1; cap_bits = '0; cap_oe = '0;
    ctl_exp = {4'h0, (rd ? 2'b10 : 2'b01), phy, rg};
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 3'h0; wdata = ctl_exp;
    n = 0; hi = 0;
    while (n < 130*H + 20) begin
      @(negedge clk); req = 1'b0; we = 1'b0; addr = 3'h0; #1;
      idle = rdata[12];
      if (mdc) hi = hi + 1;
      if (idle) break;
      n = n + 1;
      if (inj && n == 20) begin
        req = 1'b1; we = 1'b1; wdata = {4'h0, (rd ? 2'b01 : 2'b10), ~phy, ~rg};
      end
      if (inj && n == 22) begin
        req = 1'b1; we = 1'b1; addr = 3'h2; wdata = ~wv;
      end
    end
    chk(n == 130*H, "R11 busy length", 64'(n), 64'(130*H));
    chk(hi == 65*H, "R7 mdc high cycles", 64'(hi), 64'(65*H));
    chk(rise_cnt == 65, "R7 mdc periods", 64'(rise_cnt), 64'd65);
    exp_bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wv)};
    exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    chk(cap_oe == exp_oe, rd ? "R5 oe pattern" : "R4 oe pattern", cap_oe, exp_oe);
    chk((cap_bits & exp_oe) == exp_bits, rd ? "R5 header bits" : "R4 frame bits",
        cap_bits & exp_oe, exp_bits);
    chk(!oe_tail && !mdio_oe, "R11 released after frame", 64'(oe_tail), 64'd0);
    reg_rd(3'h0, v);
    chk(v == {3'b0, 1'b1, ctl_exp[11:0]}, inj ? "R9 ctl readback" : "R1 ctl readback",
        64'(v), 64'({4'h1, ctl_exp[11:0]}));
    if (inj) begin
      reg_rd(3'h2, v);
      chk(v == ~wv, "R10 data reg updated", 64'(v), 64'(~wv));
    end
  endtask

  logic [15:0] v, last_rx;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    reg_rd(3'h0, v); chk(v == 16'h1000, "R1 reset ctl", 64'(v), 64'h1000);
    reg_rd(3'h2, v); chk(v == 16'h0, "R1 reset wdata", 64'(v), 64'h0);
    reg_rd(3'h4, v); chk(v == 16'h0, "R1 reset rx", 64'(v), 64'h0);
    reg_rd(3'h6, v); chk(v == 16'h0, "R1 unmapped offset", 64'(v), 64'h0);
    chk(!mdc && !mdio_oe, "R7 idle pins after reset", 64'({mdc, mdio_oe}), 64'h0);
    reg_wr(3'h2, 16'hBEEF);
    reg_rd(3'h2, v); chk(v == 16'hBEEF, "R1 wdata readback", 64'(v), 64'hBEEF);

    // R3: reserved and null operation codes
    rise_cnt = 0;
    reg_wr(3'h0, 16'h03FF);
    reg_wr(3'h0, 16'h0C21);
    repeat (20) @(negedge clk);
    reg_rd(3'h0, v);
    chk(v == 16'h1000, "R3 invalid op ignored", 64'(v), 64'h1000);
    chk(rise_cnt == 0, "R3 no mdc activity", 64'(rise_cnt), 64'd0);

    // R2/R4/R5: sweep every address and register number in both directions
    last_rx = 16'h0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] rv, wv;
      rv = 16'(i * 16'h0841) ^ 16'hA5C3;
      wv = 16'(16'h1357 * (i + 1));
      frame(1'b1, 5'(i), 5'((i * 7 + 3) & 31), 16'h0, rv, 1'b0);
      reg_rd(3'h4, v);
      chk(v == rv, "R5 rx data", 64'(v), 64'(rv));
      last_rx = rv;
      frame(1'b0, 5'(31 - i), 5'(i), wv, 16'h0, 1'b0);
      reg_rd(3'h4, v);
      chk(v == last_rx, "R6 rx held over write", 64'(v), 64'(last_rx));
    end

    // R9/R10: accesses landing mid-frame
    frame(1'b0, 5'h15, 5'h0A, 16'hC3A5, 16'h0, 1'b1);
    reg_rd(3'h4, v);
    chk(v == last_rx, "R6 rx held after ignored write", 64'(v), 64'(last_rx));
    frame(1'b1, 5'h0B, 5'h1C, 16'h5A5A, 16'h6E91, 1'b1);
    reg_rd(3'h4, v);
    chk(v == 16'h6E91, "R9 read unaffected", 64'(v), 64'h6E91);

    // R6: invalid op after read keeps rx
    reg_wr(3'h0, 16'h0C00);
    reg_rd(3'h4, v);
    chk(v == 16'h6E91, "R6 rx held over invalid op", 64'(v), 64'h6E91);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule